// File: doc/BRIEF.md
# Split-Transaction Bus Node Interface

This block connects one device to a shared, time-multiplexed bus. The bus runs a split-transaction protocol. A read goes out as a request frame, the bus is released at once, and the data comes back later in a separate response frame from the target. A write is one request frame and gets no reply. The local device hands requests to the node through a valid/ready port. The requests wait in an output queue until the bus arbiter grants the node a slot. The node sends exactly one frame per grant cycle. The arbiter chooses the next owner while the current frame is on the bus, so granted nodes can send frames in consecutive cycles.

Frames on the bus that are addressed to this node go into an input queue. The device drains that queue at its own rate. When the input queue is full, the node raises a full indication toward the bus and turns new frames away, so the queue never overflows. When the destination of an outgoing frame reports full in the cycle the frame is driven, the sender keeps that frame at the head of its output queue and sends it again on its next grant.

Each read carries a small tag, and the responder echoes the tag in its response. The node keeps one busy bit per tag. A local read that reuses a tag still waiting for its response is held back until that response has been accepted from the bus.

Top module: `pbus_node`

## Requirements
- R1: `bus_req` is high exactly when the output queue holds at least one frame.
- R2: In a cycle with `bus_gnt` high and a non-empty output queue, `bus_out_valid` is high and the bus frame fields equal the oldest queued request, with `bus_out_src` equal to the node identity. `bus_out_valid` is low in every cycle without `bus_gnt`.
- R3: A driven frame is removed from the output queue only if `bus_nack` is low in its drive cycle. If `bus_nack` is high, the same frame is sent again, unchanged, on the next grant, and the frames behind it keep their order.
- R4: `lreq_ready` is low while the output queue holds DEPTH frames. Accepted requests leave on the bus in the order they were accepted.
- R5: A bus frame with `bus_in_valid` high and `bus_in_dst` equal to the node identity is stored when `bus_full` is low. Frames for any other destination are ignored.
- R6: `bus_full` is high exactly when the input queue holds DEPTH frames. A frame for this node that arrives while `bus_full` is high is dropped and does not overwrite any stored frame.
- R7: `rx_valid` is high exactly when the input queue is non-empty. Frames are delivered in arrival order, and one frame is removed in each cycle in which `rx_valid` and `rx_ready` are both high.
- R8: Kind codes are 2'b00 write, 2'b01 read request, 2'b10 read response. An accepted local read marks its tag busy. A local read whose tag is busy sees `lreq_ready` low. Writes and responses mark nothing. A read response for this node, once stored, frees its tag.
- R9: After reset the queues are empty, all tags are free, `bus_req`, `bus_full` and `rx_valid` are low, and `lreq_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lreq_valid | input | 1 | Local request offered |
| lreq_ready | output | 1 | Local request accepted this cycle |
| lreq_dst | input | 4 | Destination node of the request |
| lreq_kind | input | 2 | Frame kind (00 write, 01 read, 10 response) |
| lreq_tag | input | 3 | Transaction tag |
| lreq_addr | input | 16 | Address |
| lreq_data | input | 16 | Data |
| bus_req | output | 1 | Bus access wanted |
| bus_gnt | input | 1 | Bus slot granted for this cycle |
| bus_nack | input | 1 | Destination of the driven frame is full |
| bus_out_valid | output | 1 | Frame driven this cycle |
| bus_out_dst | output | 4 | Driven frame destination |
| bus_out_src | output | 4 | Driven frame source |
| bus_out_kind | output | 2 | Driven frame kind |
| bus_out_tag | output | 3 | Driven frame tag |
| bus_out_addr | output | 16 | Driven frame address |
| bus_out_data | output | 16 | Driven frame data |
| bus_in_valid | input | 1 | A frame is on the bus |
| bus_in_dst | input | 4 | Bus frame destination |
| bus_in_src | input | 4 | Bus frame source |
| bus_in_kind | input | 2 | Bus frame kind |
| bus_in_tag | input | 3 | Bus frame tag |
| bus_in_addr | input | 16 | Bus frame address |
| bus_in_data | input | 16 | Bus frame data |
| bus_full | output | 1 | Input queue cannot take another frame |
| rx_valid | output | 1 | Received frame available |
| rx_ready | input | 1 | Device takes the received frame |
| rx_src | output | 4 | Received frame source |
| rx_kind | output | 2 | Received frame kind |
| rx_tag | output | 3 | Received frame tag |
| rx_addr | output | 16 | Received frame address |
| rx_data | output | 16 | Received frame data |

## Verification
The bench builds the node with DEPTH = 4 and node identity 3. With a four-entry queue, both full boundaries can be reached in a few cycles: the stall on a full output queue and the drop of a fifth incoming frame. The node identity of 3 lets frames addressed to other nodes be mixed into the incoming traffic. Tag reuse is tested with a response that comes back while a second read is waiting, and the retry on a nacked grant is tested with further frames queued behind the nacked one.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
    localparam int ID_W   = 4;
    localparam int TAG_W  = 3;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int NTAGS  = 1 << TAG_W;

    typedef enum logic [1:0] {
        K_WRITE = 2'b00,
        K_READ  = 2'b01,
        K_RESP  = 2'b10,
        K_RSVD  = 2'b11
    } kind_e;

    typedef struct packed {
        logic [ID_W-1:0]   dst;
        logic [ID_W-1:0]   src;
        kind_e             kind;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef struct packed {
        logic [ID_W-1:0]   src;
        kind_e             kind;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    localparam int FRAME_W = $bits(frame_t);
    localparam int RXE_W   = $bits(rx_entry_t);

    function automatic logic is_read(kind_e k);
        return k == K_READ;
    endfunction

    function automatic logic is_resp(kind_e k);
        return k == K_RESP;
    endfunction

    function automatic rx_entry_t strip_dst(frame_t f);
        rx_entry_t e;
        e.src  = f.src;
        e.kind = f.kind;
        e.tag  = f.tag;
        e.addr = f.addr;
        e.data = f.data;
        return e;
    endfunction
endpackage

// File: rtl/pbus_fifo.sv
module pbus_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0]    LAST = AW'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CAP);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R6: occupancy never exceeds capacity
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        count <= CAP);

    // R6: a push into a full queue without a pop leaves occupancy unchanged
    p_full_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (count == CAP));
endmodule

// File: rtl/pbus_tag_track.sv
module pbus_tag_track
    import pbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [TAG_W-1:0] set_tag,
    input  logic             clr_en,
    input  logic [TAG_W-1:0] clr_tag,
    input  logic [TAG_W-1:0] query_tag,
    output logic             query_busy
);
    logic [NTAGS-1:0] busy;
    logic [NTAGS-1:0] set_vec, clr_vec;

    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        if (set_en) set_vec[set_tag] = 1'b1;
        if (clr_en) clr_vec[clr_tag] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) busy <= '0;
        else     busy <= (busy & ~clr_vec) | set_vec;
    end

    assign query_busy = busy[query_tag];

    // R8: a tag is never claimed twice while still waiting for its response
    p_set_free_tag_r8: assert property (@(posedge clk) disable iff (rst)
        set_en |-> !busy[set_tag]);
endmodule

// File: rtl/pbus_tx_ctrl.sv
module pbus_tx_ctrl
    import pbus_pkg::*;
(
    input  frame_t head,
    input  logic   empty,
    input  logic   gnt,
    input  logic   nack,
    output logic   req,
    output logic   out_valid,
    output frame_t out_frame,
    output logic   pop
);
    assign req       = !empty;
    assign out_valid = gnt && !empty;
    assign out_frame = head;
    assign pop       = out_valid && !nack;
endmodule

// File: rtl/pbus_rx_filter.sv
module pbus_rx_filter
    import pbus_pkg::*;
#(
    parameter logic [ID_W-1:0] MY_ID = '0
) (
    input  logic             in_valid,
    input  logic [ID_W-1:0]  in_dst,
    input  kind_e            in_kind,
    input  logic [TAG_W-1:0] in_tag,
    input  logic             q_full,
    output logic             push,
    output logic             rsp_clr,
    output logic [TAG_W-1:0] rsp_tag
);
    logic addressed;

    assign addressed = in_valid && (in_dst == MY_ID);
    assign push      = addressed && !q_full;
    assign rsp_clr   = push && is_resp(in_kind);
    assign rsp_tag   = in_tag;
endmodule

// File: rtl/pbus_node.sv
module pbus_node
    import pbus_pkg::*;
#(
    parameter int               DEPTH = 64,
    parameter logic [ID_W-1:0]  MY_ID = 4'd1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lreq_valid,
    output logic              lreq_ready,
    input  logic [ID_W-1:0]   lreq_dst,
    input  logic [1:0]        lreq_kind,
    input  logic [TAG_W-1:0]  lreq_tag,
    input  logic [ADDR_W-1:0] lreq_addr,
    input  logic [DATA_W-1:0] lreq_data,
    output logic              bus_req,
    input  logic              bus_gnt,
    input  logic              bus_nack,
    output logic              bus_out_valid,
    output logic [ID_W-1:0]   bus_out_dst,
    output logic [ID_W-1:0]   bus_out_src,
    output logic [1:0]        bus_out_kind,
    output logic [TAG_W-1:0]  bus_out_tag,
    output logic [ADDR_W-1:0] bus_out_addr,
    output logic [DATA_W-1:0] bus_out_data,
    input  logic              bus_in_valid,
    input  logic [ID_W-1:0]   bus_in_dst,
    input  logic [ID_W-1:0]   bus_in_src,
    input  logic [1:0]        bus_in_kind,
    input  logic [TAG_W-1:0]  bus_in_tag,
    input  logic [ADDR_W-1:0] bus_in_addr,
    input  logic [DATA_W-1:0] bus_in_data,
    output logic              bus_full,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic [ID_W-1:0]   rx_src,
    output logic [1:0]        rx_kind,
    output logic [TAG_W-1:0]  rx_tag,
    output logic [ADDR_W-1:0] rx_addr,
    output logic [DATA_W-1:0] rx_data
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    // ---------------- local request side ----------------
    frame_t     lreq_frame;
    logic       lreq_accept;
    logic       tag_busy;
    logic       out_full, out_empty, out_pop;
    logic [CNT_W-1:0] out_count;
    logic [FRAME_W-1:0] out_head_raw;
    frame_t     out_head, out_frame;

    always_comb begin
        lreq_frame.dst  = lreq_dst;
        lreq_frame.src  = MY_ID;
        lreq_frame.kind = kind_e'(lreq_kind);
        lreq_frame.tag  = lreq_tag;
        lreq_frame.addr = lreq_addr;
        lreq_frame.data = lreq_data;
    end

    assign lreq_ready  = !out_full && !(is_read(kind_e'(lreq_kind)) && tag_busy);
    assign lreq_accept = lreq_valid && lreq_ready;

    pbus_fifo #(.WIDTH(FRAME_W), .DEPTH(DEPTH)) u_outq (
        .clk   (clk),
        .rst   (rst),
        .push  (lreq_accept),
        .din   (lreq_frame),
        .pop   (out_pop),
        .dout  (out_head_raw),
        .empty (out_empty),
        .full  (out_full),
        .count (out_count)
    );

    assign out_head = frame_t'(out_head_raw);

    pbus_tx_ctrl u_tx (
        .head      (out_head),
        .empty     (out_empty),
        .gnt       (bus_gnt),
        .nack      (bus_nack),
        .req       (bus_req),
        .out_valid (bus_out_valid),
        .out_frame (out_frame),
        .pop       (out_pop)
    );

    assign bus_out_dst  = out_frame.dst;
    assign bus_out_src  = out_frame.src;
    assign bus_out_kind = out_frame.kind;
    assign bus_out_tag  = out_frame.tag;
    assign bus_out_addr = out_frame.addr;
    assign bus_out_data = out_frame.data;

    // ---------------- bus receive side ----------------
    frame_t     in_frame;
    rx_entry_t  in_entry, rx_head;
    logic [RXE_W-1:0] rx_head_raw;
    logic       in_push, in_full, in_empty, rx_pop;
    logic       rsp_clr;
    logic [TAG_W-1:0] rsp_tag;
    logic [CNT_W-1:0] in_count;

    always_comb begin
        in_frame.dst  = bus_in_dst;
        in_frame.src  = bus_in_src;
        in_frame.kind = kind_e'(bus_in_kind);
        in_frame.tag  = bus_in_tag;
        in_frame.addr = bus_in_addr;
        in_frame.data = bus_in_data;
        in_entry      = strip_dst(in_frame);
    end

    pbus_rx_filter #(.MY_ID(MY_ID)) u_filter (
        .in_valid (bus_in_valid),
        .in_dst   (in_frame.dst),
        .in_kind  (in_frame.kind),
        .in_tag   (in_frame.tag),
        .q_full   (in_full),
        .push     (in_push),
        .rsp_clr  (rsp_clr),
        .rsp_tag  (rsp_tag)
    );

    assign rx_pop = rx_ready && !in_empty;

    pbus_fifo #(.WIDTH(RXE_W), .DEPTH(DEPTH)) u_inq (
        .clk   (clk),
        .rst   (rst),
        .push  (in_push),
        .din   (in_entry),
        .pop   (rx_pop),
        .dout  (rx_head_raw),
        .empty (in_empty),
        .full  (in_full),
        .count (in_count)
    );

    assign rx_head  = rx_entry_t'(rx_head_raw);
    assign bus_full = in_full;
    assign rx_valid = !in_empty;
    assign rx_src   = rx_head.src;
    assign rx_kind  = rx_head.kind;
    assign rx_tag   = rx_head.tag;
    assign rx_addr  = rx_head.addr;
    assign rx_data  = rx_head.data;

    // ---------------- read tag scoreboard ----------------
    pbus_tag_track u_tags (
        .clk        (clk),
        .rst        (rst),
        .set_en     (lreq_accept && is_read(kind_e'(lreq_kind))),
        .set_tag    (lreq_tag),
        .clr_en     (rsp_clr),
        .clr_tag    (rsp_tag),
        .query_tag  (lreq_tag),
        .query_busy (tag_busy)
    );

    // ---------------- assertions ----------------
    // R1: bus request follows the output queue occupancy
    p_req_tracks_queue_r1: assert property (@(posedge clk) disable iff (rst)
        bus_req == (out_count != '0));

    // R2: nothing is driven onto the bus outside a granted slot
    p_valid_needs_grant_r2: assert property (@(posedge clk) disable iff (rst)
        bus_out_valid |-> bus_gnt);

    // R3: a rejected frame stays at the head unchanged
    p_retry_holds_head_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_out_valid && bus_nack) |=> (!out_empty && $stable(out_head)));

    // R6: while full with no drain, the input queue occupancy is frozen
    p_drop_when_full_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_full && !rx_ready) |=> $stable(in_count));
endmodule

// File: tb/pbus_node_tb.sv
`timescale 1ns/1ps
module pbus_node_tb;
    localparam int DEPTH = 4;
    localparam logic [3:0] ME = 4'd3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        lreq_valid = 0, lreq_ready;
    logic [3:0]  lreq_dst = 0;
    logic [1:0]  lreq_kind = 0;
    logic [2:0]  lreq_tag = 0;
    logic [15:0] lreq_addr = 0, lreq_data = 0;
    logic        bus_req, bus_gnt = 0, bus_nack = 0, bus_out_valid;
    logic [3:0]  bus_out_dst, bus_out_src;
    logic [1:0]  bus_out_kind;
    logic [2:0]  bus_out_tag;
    logic [15:0] bus_out_addr, bus_out_data;
    logic        bus_in_valid = 0;
    logic [3:0]  bus_in_dst = 0, bus_in_src = 0;
    logic [1:0]  bus_in_kind = 0;
    logic [2:0]  bus_in_tag = 0;
    logic [15:0] bus_in_addr = 0, bus_in_data = 0;
    logic        bus_full, rx_valid, rx_ready = 0;
    logic [3:0]  rx_src;
    logic [1:0]  rx_kind;
    logic [2:0]  rx_tag;
    logic [15:0] rx_addr, rx_data;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    pbus_node #(.DEPTH(DEPTH), .MY_ID(ME)) u_dut (.*);

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // local push: returns after the accepting edge; checks ready before the edge
    task automatic lpush(logic [3:0] d, logic [1:0] k, logic [2:0] t,
                         logic [15:0] a, logic [15:0] v, logic exp_rdy, string req);
        @(negedge clk);
        lreq_valid = 1; lreq_dst = d; lreq_kind = k; lreq_tag = t;
        lreq_addr = a; lreq_data = v;
        #1 check(req, 64'(lreq_ready), 64'(exp_rdy));
        @(negedge clk);
        lreq_valid = 0;
    endtask

    // one grant cycle; checks the driven frame {dst,src,kind,tag,addr,data}
    task automatic grant(logic nack, logic exp_v, logic [44:0] exp_f, string req);
        @(negedge clk);
        bus_gnt = 1; bus_nack = nack;
        #1 check(req, 64'(bus_out_valid), 64'(exp_v));
        if (exp_v)
            check(req, 64'({bus_out_dst, bus_out_src, bus_out_kind, bus_out_tag,
                            bus_out_addr, bus_out_data}), 64'(exp_f));
        @(negedge clk);
        bus_gnt = 0; bus_nack = 0;
    endtask

    task automatic bus_send(logic [3:0] d, logic [3:0] s, logic [1:0] k,
                            logic [2:0] t, logic [15:0] a, logic [15:0] v);
        @(negedge clk);
        bus_in_valid = 1; bus_in_dst = d; bus_in_src = s; bus_in_kind = k;
        bus_in_tag = t; bus_in_addr = a; bus_in_data = v;
        @(negedge clk);
        bus_in_valid = 0;
    endtask

    task automatic rx_take(logic [40:0] exp_e, string req);
        @(negedge clk);
        #1 check(req, 64'(rx_valid), 64'd1);
        check(req, 64'({rx_src, rx_kind, rx_tag, rx_addr, rx_data}), 64'(exp_e));
        rx_ready = 1;
        @(negedge clk);
        rx_ready = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R9 bus_req", 64'(bus_req), 64'd0);
        check("R9 bus_full", 64'(bus_full), 64'd0);
        check("R9 rx_valid", 64'(rx_valid), 64'd0);
        check("R9 lreq_ready", 64'(lreq_ready), 64'd1);
    endtask

    task automatic t_send_retry();
        lpush(4'd7, 2'b00, 3'd0, 16'h1000, 16'hAAAA, 1, "R4 accept");
        lpush(4'd5, 2'b01, 3'd1, 16'h2000, 16'h0000, 1, "R4 accept");
        lpush(4'd6, 2'b10, 3'd2, 16'h3000, 16'h5555, 1, "R4 accept");
        #1 check("R1 req with queue", 64'(bus_req), 64'd1);
        check("R2 no valid without grant", 64'(bus_out_valid), 64'd0);
        grant(1, 1, {4'd7, ME, 2'b00, 3'd0, 16'h1000, 16'hAAAA}, "R2 head frame");
        grant(0, 1, {4'd7, ME, 2'b00, 3'd0, 16'h1000, 16'hAAAA}, "R3 retry same");
        grant(0, 1, {4'd5, ME, 2'b01, 3'd1, 16'h2000, 16'h0000}, "R3 order kept");
        grant(0, 1, {4'd6, ME, 2'b10, 3'd2, 16'h3000, 16'h5555}, "R4 fifo order");
        #1 check("R1 req drops when empty", 64'(bus_req), 64'd0);
        grant(0, 0, '0, "R2 no valid when empty");
    endtask

    task automatic t_out_full();
        for (int i = 0; i < DEPTH; i++)
            lpush(4'd2, 2'b00, 3'd0, 16'(i), 16'(i + 16'h10), 1, "R4 fill");
        lpush(4'd2, 2'b00, 3'd0, 16'hFFFF, 16'hFFFF, 0, "R4 full stall");
        for (int i = 0; i < DEPTH; i++)
            grant(0, 1, {4'd2, ME, 2'b00, 3'd0, 16'(i), 16'(i + 16'h10)}, "R4 drain order");
        #1 check("R1 empty after drain", 64'(bus_req), 64'd0);
    endtask

    task automatic t_tags();
        lpush(4'd1, 2'b01, 3'd5, 16'h0050, 16'h0, 1, "R8 first read");
        lpush(4'd1, 2'b01, 3'd5, 16'h0051, 16'h0, 0, "R8 busy tag stall");
        lpush(4'd1, 2'b00, 3'd5, 16'h0052, 16'h9, 1, "R8 write ignores tag");
        lpush(4'd1, 2'b01, 3'd6, 16'h0053, 16'h0, 1, "R8 other tag free");
        bus_send(ME, 4'd1, 2'b10, 3'd5, 16'h0050, 16'hBEEF);
        lpush(4'd1, 2'b01, 3'd5, 16'h0054, 16'h0, 1, "R8 freed by response");
        grant(0, 1, {4'd1, ME, 2'b01, 3'd5, 16'h0050, 16'h0}, "R8 drain");
        grant(0, 1, {4'd1, ME, 2'b00, 3'd5, 16'h0052, 16'h9}, "R8 drain");
        grant(0, 1, {4'd1, ME, 2'b01, 3'd6, 16'h0053, 16'h0}, "R8 drain");
        grant(0, 1, {4'd1, ME, 2'b01, 3'd5, 16'h0054, 16'h0}, "R8 drain");
        rx_take({4'd1, 2'b10, 3'd5, 16'h0050, 16'hBEEF}, "R7 response delivered");
    endtask

    task automatic t_rx_filter();
        bus_send(ME, 4'd8, 2'b00, 3'd0, 16'h0A0A, 16'h1111);
        bus_send(4'd9, 4'd8, 2'b00, 3'd0, 16'h0B0B, 16'h2222);
        bus_send(ME, 4'd4, 2'b01, 3'd3, 16'h0C0C, 16'h3333);
        rx_take({4'd8, 2'b00, 3'd0, 16'h0A0A, 16'h1111}, "R5 first mine");
        rx_take({4'd4, 2'b01, 3'd3, 16'h0C0C, 16'h3333}, "R5 foreign skipped");
        @(negedge clk);
        check("R5 R7 empty after", 64'(rx_valid), 64'd0);
    endtask

    task automatic t_in_full();
        for (int i = 0; i < DEPTH; i++)
            bus_send(ME, 4'd2, 2'b00, 3'd0, 16'(i), 16'(16'h40 + i));
        check("R6 full raised", 64'(bus_full), 64'd1);
        bus_send(ME, 4'd2, 2'b00, 3'd0, 16'hDEAD, 16'hDEAD);
        rx_take({4'd2, 2'b00, 3'd0, 16'h0000, 16'h0040}, "R6 no overwrite");
        check("R6 full clears", 64'(bus_full), 64'd0);
        for (int i = 1; i < DEPTH; i++)
            rx_take({4'd2, 2'b00, 3'd0, 16'(i), 16'(16'h40 + i)}, "R7 order");
        @(negedge clk);
        check("R6 dropped frame absent", 64'(rx_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        t_reset();
        t_send_retry();
        t_out_full();
        t_tags();
        t_rx_filter();
        t_in_full();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule